// File: doc/BRIEF.md
# Indirect Internal-Bus Access Bridge

This block gives an embedded controller a path into a host-side configuration register space without addressing that space directly. The controller programs a small set of byte-wide registers. A port-select register picks either the index port or the data port of the configuration space. Writing the data register sends that byte to the selected port over a byte-wide internal bus. A read request fetches the configuration byte that the last index chose. Each outstanding cycle is tracked by its own busy flag in the control register, and that flag clears itself when the target acknowledges.

The internal bus is a level request held until a one-cycle acknowledge. The target answers a fixed, configurable number of cycles after the request. The target holds the configuration registers. Next to them sits a battery-backed scratch RAM that only the host reaches. Two host-lock bits let the controller shut the host out of either region while it works. A controller that polls a busy flag a handful of times at microsecond intervals always finds the cycle done, because a cycle takes only a few clocks.

Top module: `ibus_bridge`

## Requirements
- R1: After reset, every controller register reads zero: control (address 0), port select (address 1, 0 = index port), data (address 2), module enable (address 3) and host lock (address 4).
- R2: A data-register write (address 2), made while control bit 0 and module-enable bit 0 are set and no busy flag is set, stores the byte in the data register and sets control bit 2 (write busy). Bit 2 clears exactly ACK_LAT+1 cycles after the launching write.
- R3: A data-register write made while control bit 0 or module-enable bit 0 is clear launches nothing: no busy flag rises, the data register keeps its value and the configuration space is unchanged.
- R4: A write through the index port (port select 0) loads the index. A following write through the data port (port select 1) stores the byte in configuration entry index mod SPACE_DEPTH. The host port shows the result at that address.
- R5: Writing the control register with bits 0 and 1 set while port select is 1 sets control bit 1 (read busy). ACK_LAT+1 cycles later bit 1 clears and the data register holds the configuration entry chosen by the index.
- R6: A read request (control write with bits 0 and 1 set) while port select is 0 sets no busy flag and leaves the data register unchanged.
- R7: While either busy flag is set, a further data-register write or read request is ignored. Both flags and the data register keep their values, and no second bus cycle takes place.
- R8: With the lock bits clear, a host write with host_sel 0 stores into the configuration space and one with host_sel 1 stores into the scratch RAM. host_rdata shows the addressed entry of the selected region in the same cycle.
- R9: Lock bit 0 (address 4) drops host writes to the configuration space and forces host_rdata to zero for it. Lock bit 1 does the same for the scratch RAM. Clearing the bit exposes the contents, which were left untouched.
- R10: When a host write and an internal-bus data-port write commit to the same configuration entry on the same clock edge, the entry keeps the internal-bus byte.
- R11: The two busy flags are never set together, and every bus cycle ends within ACK_LAT+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Controller register write strobe |
| reg_addr | input | 3 | Controller register address |
| reg_wdata | input | 8 | Controller write data |
| reg_rdata | output | 8 | Controller read data for reg_addr (combinational) |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Host region: 0 configuration, 1 scratch RAM |
| host_addr | input | AW | Host entry address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed entry (combinational) |

## Verification
The configuration entry can be written by the host port and by the internal bus on the same edge, so a collision is possible. The bench provokes it by timing a host write to land exactly ACK_LAT cycles after a data-port launch. It does this once on the same entry and once a cycle later, and in both cases it judges the surviving byte through the host read port. A second overlap is the completion edge of a cycle meeting a new launch attempt, and the bench issues back-to-back requests to hit it. A behavioural model tracks the remaining cycles of each bus transfer and is compared against both read ports on every clock.

// File: rtl/ibb_pkg.sv
package ibb_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        RA_CTL  = 3'd0,
        RA_OFS  = 3'd1,
        RA_DAT  = 3'd2,
        RA_MAE  = 3'd3,
        RA_LOCK = 3'd4
    } reg_addr_e;

    localparam int CTL_EN = 0;
    localparam int CTL_RD = 1;
    localparam int CTL_WR = 2;

    localparam logic PORT_INDEX = 1'b0;
    localparam logic PORT_DATA  = 1'b1;

    typedef struct packed {
        logic          req;
        logic          we;
        logic          port;
        logic [DW-1:0] wdata;
    } ibus_req_t;

    typedef struct packed {
        logic          ack;
        logic [DW-1:0] rdata;
    } ibus_rsp_t;

    function automatic logic [DW-1:0] ctl_byte(logic en, logic rd, logic wr);
        return {5'b0, wr, rd, en};
    endfunction

endpackage

// File: rtl/ibb_ctrl.sv
module ibb_ctrl
    import ibb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output ibus_req_t     bus_req,
    input  ibus_rsp_t     bus_rsp,
    output logic [1:0]    host_lock,
    output logic          ctl_en,
    output logic          rd_busy,
    output logic          wr_busy,
    output logic [DW-1:0] data_q
);

    reg_addr_e     ra;
    logic          port_q;
    logic          mae_q;
    logic          busy;
    logic          launch_wr;
    logic          launch_rd;
    logic          req_q;
    logic          we_q;
    logic          bport_q;
    logic [DW-1:0] bdata_q;

    assign ra   = reg_addr_e'(reg_addr);
    assign busy = rd_busy | wr_busy;

    // launch conditions use register state from before this edge
    assign launch_wr = reg_wr && (ra == RA_DAT) && ctl_en && mae_q && !busy;
    assign launch_rd = reg_wr && (ra == RA_CTL) && reg_wdata[CTL_EN] && reg_wdata[CTL_RD]
                       && mae_q && (port_q == PORT_DATA) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en    <= 1'b0;
            port_q    <= PORT_INDEX;
            mae_q     <= 1'b0;
            host_lock <= 2'b00;
            data_q    <= '0;
            rd_busy   <= 1'b0;
            wr_busy   <= 1'b0;
            req_q     <= 1'b0;
            we_q      <= 1'b0;
            bport_q   <= PORT_INDEX;
            bdata_q   <= '0;
        end else begin
            if (bus_rsp.ack) begin
                req_q   <= 1'b0;
                rd_busy <= 1'b0;
                wr_busy <= 1'b0;
                if (rd_busy) data_q <= bus_rsp.rdata;
            end
            if (reg_wr) begin
                case (ra)
                    RA_CTL:  ctl_en    <= reg_wdata[CTL_EN];
                    RA_OFS:  port_q    <= reg_wdata[0];
                    RA_MAE:  mae_q     <= reg_wdata[0];
                    RA_LOCK: host_lock <= reg_wdata[1:0];
                    default: ;
                endcase
            end
            if (launch_wr) begin
                data_q  <= reg_wdata;
                wr_busy <= 1'b1;
                req_q   <= 1'b1;
                we_q    <= 1'b1;
                bport_q <= port_q;
                bdata_q <= reg_wdata;
            end
            if (launch_rd) begin
                rd_busy <= 1'b1;
                req_q   <= 1'b1;
                we_q    <= 1'b0;
                bport_q <= PORT_DATA;
            end
        end
    end

    assign bus_req = '{req: req_q, we: we_q, port: bport_q, wdata: bdata_q};

    always_comb begin
        case (ra)
            RA_CTL:  reg_rdata = ctl_byte(ctl_en, rd_busy, wr_busy);
            RA_OFS:  reg_rdata = {7'b0, port_q};
            RA_DAT:  reg_rdata = data_q;
            RA_MAE:  reg_rdata = {7'b0, mae_q};
            RA_LOCK: reg_rdata = {6'b0, host_lock};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ibb_target.sv
module ibb_target
    import ibb_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ACK_LAT = 3,
    localparam int AW     = $clog2(DEPTH),
    localparam int CNTW   = $clog2(ACK_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  ibus_req_t     bus_req,
    output ibus_rsp_t     bus_rsp,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);

    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   idx_q;
    logic [CNTW-1:0] cnt_q;
    logic            ack_q;
    logic [DW-1:0]   rdata_q;
    logic            active;
    logic            at_end;

    assign active = bus_req.req && !ack_q;
    assign at_end = (cnt_q == CNTW'(ACK_LAT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            // host first, bus later: the bus byte survives a same-edge collision
            if (host_we) mem[host_addr] <= host_wdata;
            if (active) begin
                if (at_end) begin
                    cnt_q <= '0;
                    ack_q <= 1'b1;
                    if (bus_req.we) begin
                        if (bus_req.port == PORT_INDEX) idx_q <= bus_req.wdata[AW-1:0];
                        else                            mem[idx_q] <= bus_req.wdata;
                    end else begin
                        rdata_q <= mem[idx_q];
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                ack_q <= 1'b0;
            end
        end
    end

    assign bus_rsp    = '{ack: ack_q, rdata: rdata_q};
    assign host_rdata = mem[host_addr];

endmodule

// File: rtl/ibb_bram.sv
module ibb_bram
    import ibb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/ibus_bridge.sv
module ibus_bridge
    import ibb_pkg::*;
#(
    parameter int SPACE_DEPTH = 16,
    parameter int ACK_LAT     = 3,
    localparam int AW         = $clog2(SPACE_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          host_wr,
    input  logic          host_sel,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata
);

    ibus_req_t     bus_req;
    ibus_rsp_t     bus_rsp;
    logic [1:0]    host_lock;
    logic          ctl_en;
    logic          rd_busy;
    logic          wr_busy;
    logic [DW-1:0] data_q;
    logic [DW-1:0] cfg_rd;
    logic [DW-1:0] bram_rd;
    logic          cfg_hwe;
    logic          bram_hwe;

    assign cfg_hwe  = host_wr && !host_sel && !host_lock[0];
    assign bram_hwe = host_wr &&  host_sel && !host_lock[1];

    ibb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_req   (bus_req),
        .bus_rsp   (bus_rsp),
        .host_lock (host_lock),
        .ctl_en    (ctl_en),
        .rd_busy   (rd_busy),
        .wr_busy   (wr_busy),
        .data_q    (data_q)
    );

    ibb_target #(.DEPTH(SPACE_DEPTH), .ACK_LAT(ACK_LAT)) u_target (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_rsp    (bus_rsp),
        .host_we    (cfg_hwe),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (cfg_rd)
    );

    ibb_bram #(.DEPTH(SPACE_DEPTH)) u_bram (
        .clk   (clk),
        .rst   (rst),
        .we    (bram_hwe),
        .addr  (host_addr),
        .wdata (host_wdata),
        .rdata (bram_rd)
    );

    always_comb begin
        if (host_sel) host_rdata = host_lock[1] ? '0 : bram_rd;
        else          host_rdata = host_lock[0] ? '0 : cfg_rd;
    end

endmodule

// File: rtl/ibus_bridge_chk.sv
module ibus_bridge_chk #(
    parameter int ACK_LAT = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       ctl_en,
    input logic       rd_busy,
    input logic       wr_busy,
    input logic       bus_req_v,
    input logic       bus_ack,
    input logic [7:0] data_q,
    input logic [1:0] host_lock,
    input logic       host_sel,
    input logic [7:0] host_rdata
);

    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)                      busy_run <= '0;
        else if (rd_busy || wr_busy)  busy_run <= busy_run + 16'd1;
        else                          busy_run <= '0;
    end

    a_r11_one_busy: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && wr_busy));

    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> (!rd_busy && !wr_busy));

    a_r11_window: assert property (@(posedge clk) disable iff (rst)
        busy_run <= 16'(ACK_LAT + 1));

    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> bus_req_v);

    a_r7_busy_holds_data: assert property (@(posedge clk) disable iff (rst)
        ((rd_busy || wr_busy) && !bus_ack && reg_wr && reg_addr == 3'd2) |=> $stable(data_q));

    a_r3_disabled_no_launch: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd2 && !ctl_en && !rd_busy && !wr_busy) |=> !wr_busy);

    a_r9_cfg_locked_zero: assert property (@(posedge clk) disable iff (rst)
        (!host_sel && host_lock[0]) |-> host_rdata == 8'h00);

    a_r9_bram_locked_zero: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_lock[1]) |-> host_rdata == 8'h00);

endmodule

bind ibus_bridge ibus_bridge_chk #(.ACK_LAT(ACK_LAT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .ctl_en     (ctl_en),
    .rd_busy    (rd_busy),
    .wr_busy    (wr_busy),
    .bus_req_v  (bus_req.req),
    .bus_ack    (bus_rsp.ack),
    .data_q     (data_q),
    .host_lock  (host_lock),
    .host_sel   (host_sel),
    .host_rdata (host_rdata)
);

// File: tb/ibus_bridge_test.sv
`timescale 1ns/1ps
module ibus_bridge_test;

    localparam int LAT   = 3;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       host_wr = 1'b0;
    logic       host_sel = 1'b0;
    logic [3:0] host_addr = 4'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    always #2.5 clk = ~clk;

    ibus_bridge #(.SPACE_DEPTH(DEPTH), .ACK_LAT(LAT)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_wr(host_wr),
        .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    int    vecs = 0;
    int    errs = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic       m_en, m_port, m_mae, m_rb, m_wb;
    logic [1:0] m_lock;
    logic [7:0] m_dat, m_tmp, m_opd;
    logic       m_opwe, m_opport;
    logic [3:0] m_idx;
    int         m_rem;
    logic [7:0] m_cfg [DEPTH];
    logic [7:0] m_bram [DEPTH];

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_port = 0; m_mae = 0; m_rb = 0; m_wb = 0; m_lock = 0;
            m_dat = 0; m_tmp = 0; m_opd = 0; m_opwe = 0; m_opport = 0; m_idx = 0; m_rem = 0;
            for (int i = 0; i < DEPTH; i++) begin m_cfg[i] = 0; m_bram[i] = 0; end
        end else begin
            bit   o_busy, o_en, o_mae, o_port, commit, finish;
            logic [1:0] o_lock;
            o_busy = m_rb | m_wb; o_en = m_en; o_mae = m_mae; o_port = m_port; o_lock = m_lock;
            commit = 0; finish = 0;
            if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 1) commit = 1;
                if (m_rem == 0) finish = 1;
            end
            if (commit && !m_opwe) m_tmp = m_cfg[m_idx];
            if (host_wr) begin
                if (!host_sel && !o_lock[0]) m_cfg[host_addr] = host_wdata;
                if ( host_sel && !o_lock[1]) m_bram[host_addr] = host_wdata;
            end
            if (commit && m_opwe) begin
                if (!m_opport) m_idx = m_opd[3:0];
                else           m_cfg[m_idx] = m_opd;
            end
            if (finish) begin
                if (m_rb) m_dat = m_tmp;
                m_rb = 0; m_wb = 0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin
                        m_en = reg_wdata[0];
                        if (reg_wdata[0] && reg_wdata[1] && o_mae && o_port && !o_busy) begin
                            m_rb = 1; m_opwe = 0; m_rem = LAT + 1;
                        end
                    end
                    3'd1: m_port = reg_wdata[0];
                    3'd2: if (o_en && o_mae && !o_busy) begin
                        m_dat = reg_wdata; m_wb = 1; m_opwe = 1; m_opport = o_port;
                        m_opd = reg_wdata; m_rem = LAT + 1;
                    end
                    3'd3: m_mae = reg_wdata[0];
                    3'd4: m_lock = reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_reg();
        case (reg_addr)
            3'd0: return {5'b0, m_wb, m_rb, m_en};
            3'd1: return {7'b0, m_port};
            3'd2: return m_dat;
            3'd3: return {7'b0, m_mae};
            3'd4: return {6'b0, m_lock};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_host();
        if (host_sel) return m_lock[1] ? 8'h00 : m_bram[host_addr];
        return m_lock[0] ? 8'h00 : m_cfg[host_addr];
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] e;
            e = exp_reg();
            vecs++;
            if (reg_rdata !== e) begin
                errs++;
                $display("FAIL %s reg_rdata addr %0d got %02h expected %02h", cur_req, reg_addr, reg_rdata, e);
            end
            e = exp_host();
            vecs++;
            if (host_rdata !== e) begin
                errs++;
                $display("FAIL %s host_rdata sel %0d addr %0d got %02h expected %02h",
                         cur_req, host_sel, host_addr, host_rdata, e);
            end
        end
    end

    task automatic regw(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n, input logic [2:0] a);
        reg_addr = a;
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic hostw(input logic s, input logic [3:0] a, input logic [7:0] d);
        host_sel = s; host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic look(input logic s, input logic [3:0] a);
        host_sel = s; host_addr = a;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        #500000;
        errs++;
        $display("FAIL watchdog expired under %s", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        cur_req = "R1";
        for (int k = 0; k < 5; k++) idle(1, 3'(k));

        cur_req = "R8";
        hostw(1'b0, 4'd3, 8'h11);
        hostw(1'b1, 4'd2, 8'h22);
        look(1'b0, 4'd3); look(1'b1, 4'd2); look(1'b0, 4'd2);

        cur_req = "R3";
        regw(3'd2, 8'hE1); idle(3, 3'd0); idle(1, 3'd2);
        regw(3'd3, 8'h01); regw(3'd2, 8'hE2); idle(3, 3'd0); idle(1, 3'd2);
        regw(3'd3, 8'h00); regw(3'd0, 8'h01); regw(3'd2, 8'hE3); idle(3, 3'd0); idle(1, 3'd2);

        cur_req = "R2/R4/R11";
        regw(3'd3, 8'h01); regw(3'd1, 8'h00);
        regw(3'd2, 8'h23); idle(6, 3'd0);
        regw(3'd1, 8'h01);
        regw(3'd2, 8'h5A); idle(6, 3'd0); idle(1, 3'd2);
        look(1'b0, 4'd3);

        cur_req = "R5";
        hostw(1'b0, 4'd7, 8'h77);
        regw(3'd1, 8'h00); regw(3'd2, 8'h07); idle(6, 3'd0);
        regw(3'd1, 8'h01); regw(3'd0, 8'h03); idle(6, 3'd0); idle(1, 3'd2);

        cur_req = "R6";
        regw(3'd1, 8'h00); regw(3'd0, 8'h03); idle(4, 3'd0); idle(1, 3'd2);

        cur_req = "R7";
        regw(3'd1, 8'h01);
        regw(3'd2, 8'h3C); regw(3'd2, 8'hC3); regw(3'd0, 8'h03);
        idle(4, 3'd0); idle(1, 3'd2); look(1'b0, 4'd7);
        regw(3'd0, 8'h03); regw(3'd2, 8'h99); regw(3'd0, 8'h03);
        idle(5, 3'd0); idle(1, 3'd2); look(1'b0, 4'd7);

        cur_req = "R10";
        regw(3'd1, 8'h00); regw(3'd2, 8'h09); idle(6, 3'd0);
        regw(3'd1, 8'h01);
        regw(3'd2, 8'hAB); idle(2, 3'd0); hostw(1'b0, 4'd9, 8'hCD);
        idle(3, 3'd0); look(1'b0, 4'd9);
        regw(3'd2, 8'h44); idle(3, 3'd0); hostw(1'b0, 4'd9, 8'h55);
        idle(2, 3'd0); look(1'b0, 4'd9);

        cur_req = "R9";
        regw(3'd4, 8'h01);
        hostw(1'b0, 4'd1, 8'h99); look(1'b0, 4'd1); look(1'b0, 4'd3); look(1'b1, 4'd2);
        regw(3'd4, 8'h02);
        hostw(1'b1, 4'd2, 8'h66); look(1'b1, 4'd2); look(1'b0, 4'd3);
        regw(3'd4, 8'h00);
        look(1'b0, 4'd1); look(1'b1, 4'd2); idle(1, 3'd4);

        finish_run();
    end

endmodule